// File: doc/BRIEF.md
# Receive DMA Run/Stop Controller

This block sequences the receive side of a descriptor-driven DMA engine. Software controls it with a level run bit and a descriptor-list base address. The receive datapath reports frame starts and frame ends. A descriptor walker serves fetch and close requests through request/acknowledge handshakes. The block keeps the current descriptor pointer and reports its state on a status output. It also raises one-cycle events for a completed frame, an unavailable buffer, a stop and a start that came too early.

A stop never cuts a frame short. Clearing the run bit while a frame is in flight has no effect until the engine has closed that frame's descriptor, fetched the next one and settled in the waiting state. Stopping keeps the pointer to that next descriptor, and a later start resumes from it. The base address is used again only on the first start after reset, or on the first start after the base has been rewritten.

Top module: `rx_dma_runctl`

## Requirements
- R1: After reset the state output is STOPPED (code 0), the pointer is 0, and no request or event output is high.
- R2: In STOPPED, with run high and a base address programmed, the block moves to FETCH_DESC (code 1) and raises the fetch request at the pointer. The pointer is loaded from the base on the first start after reset or after a base write.
- R3: A fetch acknowledge with the descriptor owned by the DMA leads to WAIT_PKT (code 2). Without ownership it leads to SUSPENDED (code 5), and the buffer-unavailable event is high for exactly that first cycle.
- R4: A frame start in WAIT_PKT leads to RECEIVE (code 3). A frame end leads to CLOSE_DESC (code 4) with the close request high. The close acknowledge adds DESC_BYTES to the pointer, pulses the frame-done event for one cycle and returns to FETCH_DESC.
- R5: A low run bit in FETCH_DESC, RECEIVE or CLOSE_DESC does not stop the engine. The stop takes effect only once WAIT_PKT is reached.
- R6: A low run bit in WAIT_PKT or SUSPENDED moves to STOPPED, and the stopped event is high for exactly that first cycle. In WAIT_PKT the stop takes priority over a frame start in the same cycle.
- R7: A restart with no base write since the last start resumes fetching at the pointer kept at the stop, not at the base.
- R8: A base write between a stop and a restart makes the restart fetch from the new base.
- R9: A run rising edge with no base ever programmed leaves the block in STOPPED and pulses the start-error event for one cycle.
- R10: A poll in SUSPENDED with run high moves to FETCH_DESC and fetches the same pointer again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Software run bit (level) |
| base_wr_i | input | 1 | Base address write strobe |
| base_addr_i | input | AW | Descriptor-list base address |
| poll_i | input | 1 | Retry request while suspended |
| fetch_req_o | output | 1 | Descriptor fetch request |
| fetch_addr_o | output | AW | Address of the descriptor to fetch |
| fetch_ack_i | input | 1 | Fetch completed |
| desc_owned_i | input | 1 | Fetched descriptor is owned by the DMA (valid with fetch_ack_i) |
| frame_start_i | input | 1 | Datapath began a frame |
| frame_end_i | input | 1 | Datapath finished a frame |
| close_req_o | output | 1 | Descriptor close (write-back) request |
| close_ack_i | input | 1 | Close completed |
| state_o | output | 3 | Current state code |
| cur_ptr_o | output | AW | Current descriptor pointer |
| rx_done_o | output | 1 | Frame-done event |
| rx_unavail_o | output | 1 | Buffer-unavailable event |
| rx_stopped_o | output | 1 | Entered-stopped event |
| start_err_o | output | 1 | Start attempted without a base address |

## Verification
The run bit is cleared at several points: in the middle of a frame, while a descriptor is being fetched, while waiting, while suspended, and in the same cycle as a frame start. These cases separate a design that stops only at a frame boundary from one that stops at once, and they show whether the stop wins over a new frame. Restarts are tried both with and without a base rewrite, which shows whether the kept pointer or the base is reloaded. Descriptors that are not owned, followed by polls, exercise the suspend and retry path. A start before any base is programmed exercises the error event.

// File: rtl/rx_dma_runctl_pkg.sv
package rx_dma_runctl_pkg;
  typedef enum logic [2:0] {
    ST_STOPPED   = 3'd0,
    ST_FETCH     = 3'd1,
    ST_WAIT_PKT  = 3'd2,
    ST_RECEIVE   = 3'd3,
    ST_CLOSE     = 3'd4,
    ST_SUSPENDED = 3'd5
  } rx_state_e;
endpackage

// File: rtl/rx_dma_ptr.sv
module rx_dma_ptr #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          load_i,
  input  logic          adv_i,
  output logic          base_valid_o,
  output logic [AW-1:0] cur_ptr_o
);
  localparam logic [AW-1:0] STEP = AW'(DESC_BYTES);

  logic [AW-1:0] base_q, ptr_q;
  logic          valid_q, fresh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      ptr_q   <= '0;
      valid_q <= 1'b0;
      fresh_q <= 1'b0;
    end else begin
      if (load_i) begin
        // fresh base wins over the kept position
        if (fresh_q) ptr_q <= base_q;
        fresh_q <= 1'b0;
      end else if (adv_i) begin
        ptr_q <= ptr_q + STEP;
      end
      if (base_wr_i) begin
        base_q  <= base_addr_i;
        valid_q <= 1'b1;
        fresh_q <= 1'b1;
      end
    end
  end

  assign base_valid_o = valid_q;
  assign cur_ptr_o    = ptr_q;
endmodule

// File: rtl/rx_dma_fsm.sv
module rx_dma_fsm
  import rx_dma_runctl_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      run_i,
  input  logic      base_valid_i,
  input  logic      poll_i,
  input  logic      fetch_ack_i,
  input  logic      desc_owned_i,
  input  logic      frame_start_i,
  input  logic      frame_end_i,
  input  logic      close_ack_i,
  output rx_state_e state_o,
  output logic      load_o,
  output logic      adv_o,
  output logic      rx_done_o,
  output logic      rx_unavail_o,
  output logic      rx_stopped_o,
  output logic      start_err_o
);
  rx_state_e state_q, state_d;
  logic run_q;
  logic done_d, unav_d, stop_d, err_d;

  always_comb begin
    state_d = state_q;
    load_o  = 1'b0;
    adv_o   = 1'b0;
    done_d  = 1'b0;
    unav_d  = 1'b0;
    stop_d  = 1'b0;
    err_d   = 1'b0;
    unique case (state_q)
      ST_STOPPED: begin
        if (run_i && base_valid_i) begin
          state_d = ST_FETCH;
          load_o  = 1'b1;
        end else if (run_i && !run_q) begin
          err_d = 1'b1;
        end
      end
      ST_FETCH: begin
        if (fetch_ack_i) begin
          if (desc_owned_i) state_d = ST_WAIT_PKT;
          else begin
            state_d = ST_SUSPENDED;
            unav_d  = 1'b1;
          end
        end
      end
      ST_WAIT_PKT: begin
        if (!run_i) begin
          state_d = ST_STOPPED;
          stop_d  = 1'b1;
        end else if (frame_start_i) begin
          state_d = ST_RECEIVE;
        end
      end
      ST_RECEIVE: if (frame_end_i) state_d = ST_CLOSE;
      ST_CLOSE: begin
        if (close_ack_i) begin
          state_d = ST_FETCH;
          adv_o   = 1'b1;
          done_d  = 1'b1;
        end
      end
      ST_SUSPENDED: begin
        if (!run_i) begin
          state_d = ST_STOPPED;
          stop_d  = 1'b1;
        end else if (poll_i) begin
          state_d = ST_FETCH;
        end
      end
      default: state_d = ST_STOPPED;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_STOPPED;
      run_q        <= 1'b0;
      rx_done_o    <= 1'b0;
      rx_unavail_o <= 1'b0;
      rx_stopped_o <= 1'b0;
      start_err_o  <= 1'b0;
    end else begin
      state_q      <= state_d;
      run_q        <= run_i;
      rx_done_o    <= done_d;
      rx_unavail_o <= unav_d;
      rx_stopped_o <= stop_d;
      start_err_o  <= err_d;
    end
  end

  assign state_o = state_q;
endmodule

// File: rtl/rx_dma_runctl.sv
module rx_dma_runctl
  import rx_dma_runctl_pkg::*;
#(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          base_wr_i,
  input  logic [AW-1:0] base_addr_i,
  input  logic          poll_i,
  output logic          fetch_req_o,
  output logic [AW-1:0] fetch_addr_o,
  input  logic          fetch_ack_i,
  input  logic          desc_owned_i,
  input  logic          frame_start_i,
  input  logic          frame_end_i,
  output logic          close_req_o,
  input  logic          close_ack_i,
  output logic [2:0]    state_o,
  output logic [AW-1:0] cur_ptr_o,
  output logic          rx_done_o,
  output logic          rx_unavail_o,
  output logic          rx_stopped_o,
  output logic          start_err_o
);
  rx_state_e st;
  logic      load, adv, base_valid;

  rx_dma_fsm u_fsm (
    .clk_i, .rst_ni, .run_i,
    .base_valid_i (base_valid),
    .poll_i, .fetch_ack_i, .desc_owned_i,
    .frame_start_i, .frame_end_i, .close_ack_i,
    .state_o      (st),
    .load_o       (load),
    .adv_o        (adv),
    .rx_done_o, .rx_unavail_o, .rx_stopped_o, .start_err_o
  );

  rx_dma_ptr #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_ptr (
    .clk_i, .rst_ni, .base_wr_i, .base_addr_i,
    .load_i       (load),
    .adv_i        (adv),
    .base_valid_o (base_valid),
    .cur_ptr_o
  );

  assign state_o      = st;
  assign fetch_req_o  = (st == ST_FETCH);
  assign close_req_o  = (st == ST_CLOSE);
  assign fetch_addr_o = cur_ptr_o;
endmodule

// File: rtl/rx_dma_runctl_chk.sv
module rx_dma_runctl_chk #(
  parameter int AW         = 32,
  parameter int DESC_BYTES = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [2:0]    state_o,
  input logic [AW-1:0] cur_ptr_o,
  input logic          close_ack_i,
  input logic          rx_done_o,
  input logic          rx_unavail_o,
  input logic          rx_stopped_o,
  input logic          start_err_o
);
  a_r3_unavail_in_susp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_unavail_o |-> state_o == 3'd5);
  a_r6_stop_pulse_on_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_stopped_o |-> (state_o == 3'd0 && $past(state_o) != 3'd0));
  a_r5_frame_not_cut: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd3 |=> (state_o == 3'd3 || state_o == 3'd4));
  a_r4_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == 3'd4 && close_ack_i) |=> cur_ptr_o == $past(cur_ptr_o) + AW'(DESC_BYTES));
  a_r7_ptr_kept_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_o == 3'd0 |=> (state_o != 3'd0 || $stable(cur_ptr_o)));
  a_r9_err_while_stopped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_err_o |-> state_o == 3'd0);
  a_r1_events_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rx_done_o, rx_unavail_o, rx_stopped_o, start_err_o}));
endmodule

bind rx_dma_runctl rx_dma_runctl_chk #(.AW(AW), .DESC_BYTES(DESC_BYTES)) u_chk (
  .clk_i, .rst_ni, .state_o, .cur_ptr_o, .close_ack_i,
  .rx_done_o, .rx_unavail_o, .rx_stopped_o, .start_err_o
);

// File: tb/rx_dma_runctl_test.sv
`timescale 1ns/1ps
module rx_dma_runctl_test;
  localparam int AW = 32;
  localparam int DB = 16;

  logic clk = 0, rst_n = 0;
  logic run = 0, bwr = 0, poll = 0, fack = 0, own = 0, fs = 0, fe = 0, cack = 0;
  logic [AW-1:0] baddr = '0;
  logic fetch_req, close_req, done, unav, stopped, serr;
  logic [AW-1:0] faddr, ptr;
  logic [2:0] st;

  always #10 clk = ~clk;

  rx_dma_runctl #(.AW(AW), .DESC_BYTES(DB)) uut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .base_wr_i(bwr), .base_addr_i(baddr),
    .poll_i(poll), .fetch_req_o(fetch_req), .fetch_addr_o(faddr), .fetch_ack_i(fack),
    .desc_owned_i(own), .frame_start_i(fs), .frame_end_i(fe), .close_req_o(close_req),
    .close_ack_i(cack), .state_o(st), .cur_ptr_o(ptr), .rx_done_o(done),
    .rx_unavail_o(unav), .rx_stopped_o(stopped), .start_err_o(serr)
  );

  int checks = 0, fails = 0;
  string phase = "R1";

  // behavioural reference
  int m_st = 0;
  longint unsigned m_ptr = 0, m_base = 0;
  bit m_bv = 0, m_fresh = 0, m_runq = 0;
  bit e_done = 0, e_unav = 0, e_stop = 0, e_err = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_base = 0; m_bv = 0; m_fresh = 0; m_runq = 0;
      e_done = 0; e_unav = 0; e_stop = 0; e_err = 0;
    end else begin
      e_done = 0; e_unav = 0; e_stop = 0; e_err = 0;
      if (m_st == 0) begin
        if (run && m_bv) begin
          m_st = 1;
          if (m_fresh) m_ptr = m_base;
          m_fresh = 0;
        end else if (run && !m_runq) e_err = 1;
      end else if (m_st == 1) begin
        if (fack) begin
          if (own) m_st = 2;
          else begin m_st = 5; e_unav = 1; end
        end
      end else if (m_st == 2) begin
        if (!run) begin m_st = 0; e_stop = 1; end
        else if (fs) m_st = 3;
      end else if (m_st == 3) begin
        if (fe) m_st = 4;
      end else if (m_st == 4) begin
        if (cack) begin m_st = 1; m_ptr = (m_ptr + DB) & 64'hFFFF_FFFF; e_done = 1; end
      end else if (m_st == 5) begin
        if (!run) begin m_st = 0; e_stop = 1; end
        else if (poll) m_st = 1;
      end
      if (bwr) begin m_base = baddr; m_bv = 1; m_fresh = 1; end
      m_runq = run;
    end
  end

  task automatic chk(input bit ok, input string what, input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(st == 3'(m_st), "state", st, m_st);
    chk(ptr == AW'(m_ptr), "pointer", ptr, m_ptr);
    chk(fetch_req == (m_st == 1), "fetch_req", fetch_req, m_st == 1);
    if (m_st == 1) chk(faddr == AW'(m_ptr), "fetch_addr", faddr, m_ptr);
    chk(close_req == (m_st == 4), "close_req", close_req, m_st == 4);
    chk(done == e_done, "rx_done", done, e_done);
    chk(unav == e_unav, "rx_unavail", unav, e_unav);
    chk(stopped == e_stop, "rx_stopped", stopped, e_stop);
    chk(serr == e_err, "start_err", serr, e_err);
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      compare();
      bwr = 0; poll = 0; fack = 0; own = 0; fs = 0; fe = 0; cack = 0;
    end
  endtask

  // one full frame from WAIT_PKT back to WAIT_PKT (R4)
  task automatic frame(input bit drop_run);
    fs = 1; step();
    if (drop_run) run = 0;
    step(2);
    fe = 1; step();
    step();
    cack = 1; step();
    fack = 1; own = 1; step();
  endtask

  initial begin
    #1;
    @(negedge clk);
    compare();
    rst_n = 1;
    step(2);

    phase = "R9"; run = 1; step(3); run = 0; step(2);

    phase = "R2"; baddr = 32'h1000; bwr = 1; step(); run = 1; step(2);
    phase = "R3"; fack = 1; own = 1; step(2);
    phase = "R4"; frame(0); step();

    phase = "R5"; frame(1); step(2);
    phase = "R6"; step(2);

    phase = "R7"; run = 1; step(2);
    phase = "R3"; fack = 1; own = 0; step(2);
    phase = "R10"; poll = 1; step(2); fack = 1; own = 0; step(2);
    phase = "R6"; run = 0; step(3);

    phase = "R8"; baddr = 32'h2000; bwr = 1; step(); run = 1; step(2);
    fack = 1; own = 1; step();
    phase = "R6"; run = 0; fs = 1; step(3);

    phase = "R5"; run = 1; step(); run = 0; step(2); fack = 1; own = 1; step(3);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule